// File: doc/BRIEF.md
# Dual Reference Selector and Divider

This block prepares the two reference inputs of a clock-recovery loop. It has a primary path and a secondary path, and the two are identical and independent. Each path selects one source clock, brings it into the system clock domain, counts its rising edges, and emits a strobe one system clock wide once every N source edges. The source can be any of the stream clocks or that path's own external reference pin. N is a 12-bit programmable divide ratio, so a fast line clock can be reduced to the loop's comparison rate. For example, a ratio of 537 takes 34.368 MHz down to 64 kHz. Both paths are expected to carry the same nominal rate after division, so the loop can switch between them.

Software programs each path through a single write port. A ratio of zero turns the path off: no strobe leaves it. A write to a path's ratio or source select restarts that path's count. The loop therefore never sees a short period that mixes the old setting and the new one. The phase detector, loop filter and oscillator sit downstream and are not part of this block.

Top module: `refdiv_pair`

## Requirements
- R1: The two paths are independent. A write with `wr_addr[1]`=0 programs the primary path and a write with `wr_addr[1]`=1 programs the secondary path. Within a path, `wr_addr[0]`=0 selects the divide ratio (`wr_data[11:0]`) and `wr_addr[0]`=1 selects the source select (`wr_data[2:0]`). Programming one path never changes the strobes of the other.
- R2: A source select value k from 0 to 3 picks `stream_clk[k]`. Any value from 4 to 7 picks the path's own external pin: `pri_ext_ref` for the primary path and `sec_ext_ref` for the secondary path.
- R3: With a ratio N of 1 or more, a path emits one strobe per N rising edges of its selected source. The strobe period equals N source periods, and N=1 passes every source edge through.
- R4: With a ratio of 0, the path emits no strobe at all, including from the cycle after the write that sets it.
- R5: Every strobe is exactly one system clock wide.
- R6: A write to a path's ratio or source select clears that path's count. Source activity during the three system clocks after the write is ignored. With a steady source, the first strobe after the write follows the Nth source rising edge after the write. No strobe is emitted in the cycle after any write to the path.
- R7: After reset both ratios are 0 and both selects are 0, so neither path emits a strobe.
- R8: The full 12-bit ratio range is usable. A ratio of 537 gives a period of 537 source periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling and strobes are in this domain |
| rst_n | input | 1 | Active-low synchronous reset |
| stream_clk | input | NUM_STREAMS | Stream clocks that either path may select |
| pri_ext_ref | input | 1 | External reference pin available only to the primary path |
| sec_ext_ref | input | 1 | External reference pin available only to the secondary path |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Bit 1 chooses the path, bit 0 chooses ratio (0) or select (1) |
| wr_data | input | DIV_W | Write data: the ratio, or the source select in the low bits |
| pri_tick | output | 1 | Primary divided reference strobe |
| sec_tick | output | 1 | Secondary divided reference strobe |

## Verification
The hardest case to reach is a reconfiguration that lands while a source edge is still in flight through the synchronizer. It is also the case where switching sources makes the selected input appear to rise. Either of these could add a spurious count to the first period after the write. The bench reproduces this case deliberately. It waits for a rising edge of the new source, then writes a few clocks later while that source is high and the old one may be low. It then counts source edges from the write up to the first strobe and expects exactly N. Periods are swept over every source on both paths with several ratios, plus one large ratio. Each measured period is compared against N times the known source period.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
   // field selected by wr_addr[0] within a path
   typedef enum logic {
      FLD_RATIO  = 1'b0,
      FLD_SOURCE = 1'b1
   } refdiv_fld_e;

   localparam int unsigned REFDIV_PATHS = 2;

   function automatic int unsigned sel_width(input int unsigned streams);
      return $clog2(streams + 1);
   endfunction
endpackage

// File: rtl/refdiv_edge.sv
module refdiv_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("refdiv_edge: STAGES must be at least 2");
      end
   endgenerate

   // sh[STAGES-1] is the synchronized level, sh[STAGES] its delayed copy
   logic [STAGES:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], din};
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/refdiv_count.sv
module refdiv_count #(
   parameter int unsigned DIV_W = 12,
   parameter int unsigned BLANK = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             rise,
   input  logic [DIV_W-1:0] ratio,
   output logic             tick
);
   localparam int unsigned BW = (BLANK < 1) ? 1 : $clog2(BLANK + 1);

   logic [DIV_W-1:0] cnt;
   logic [BW-1:0]    blank;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         tick  <= 1'b0;
         blank <= '0;
      end else if (clr) begin
         cnt   <= '0;
         tick  <= 1'b0;
         blank <= BW'(BLANK);
      end else begin
         tick <= 1'b0;
         if (blank != '0) begin
            blank <= blank - BW'(1);
         end else if (rise && (ratio != '0)) begin
            if (cnt >= ratio - DIV_W'(1)) begin
               cnt  <= '0;
               tick <= 1'b1;
            end else begin
               cnt <= cnt + DIV_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/refdiv_path.sv
module refdiv_path #(
   parameter int unsigned NUM_STREAMS = 4,
   parameter int unsigned DIV_W       = 12,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BLANK       = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_STREAMS-1:0] streams,
   input  logic                   ext_ref,
   input  logic                   wr_ratio,
   input  logic                   wr_source,
   input  logic [DIV_W-1:0]       wr_data,
   output logic                   tick
);
   logic [DIV_W-1:0] ratio_q;
   logic [SEL_W-1:0] sel_q;
   logic             src;
   logic             rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ratio_q <= '0;
         sel_q   <= '0;
      end else begin
         if (wr_ratio)  ratio_q <= wr_data;
         if (wr_source) sel_q   <= wr_data[SEL_W-1:0];
      end
   end

   // codes below NUM_STREAMS pick a stream, all others the path's own pin
   always_comb begin
      src = ext_ref;
      for (int k = 0; k < int'(NUM_STREAMS); k++) begin
         if (sel_q == SEL_W'(k)) src = streams[k];
      end
   end

   refdiv_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (src),
      .rise (rise)
   );

   refdiv_count #(.DIV_W(DIV_W), .BLANK(BLANK)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (wr_ratio | wr_source),
      .rise (rise),
      .ratio(ratio_q),
      .tick (tick)
   );
endmodule

// File: rtl/refdiv_pair.sv
module refdiv_pair
   import refdiv_pkg::*;
#(
   parameter int unsigned NUM_STREAMS = 4,
   parameter int unsigned DIV_W       = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BLANK       = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_STREAMS-1:0] stream_clk,
   input  logic                   pri_ext_ref,
   input  logic                   sec_ext_ref,
   input  logic                   wr_en,
   input  logic [1:0]             wr_addr,
   input  logic [DIV_W-1:0]       wr_data,
   output logic                   pri_tick,
   output logic                   sec_tick
);
   localparam int unsigned SEL_W = sel_width(NUM_STREAMS);

   generate
      if (NUM_STREAMS < 1 || NUM_STREAMS > 15) begin : g_bad_streams
         $error("refdiv_pair: NUM_STREAMS out of range");
      end
      if (DIV_W < 2 || DIV_W < SEL_W) begin : g_bad_width
         $error("refdiv_pair: DIV_W too narrow");
      end
      if (BLANK < SYNC_STAGES + 1) begin : g_bad_blank
         $error("refdiv_pair: BLANK must cover the synchronizer depth");
      end
   endgenerate

   logic [REFDIV_PATHS-1:0] ext_v;
   logic [REFDIV_PATHS-1:0] tick_v;

   assign ext_v = {sec_ext_ref, pri_ext_ref};

   for (genvar p = 0; p < int'(REFDIV_PATHS); p++) begin : g_path
      logic hit;
      assign hit = wr_en && (wr_addr[1] == 1'(p));

      refdiv_path #(
         .NUM_STREAMS(NUM_STREAMS),
         .DIV_W      (DIV_W),
         .SEL_W      (SEL_W),
         .SYNC_STAGES(SYNC_STAGES),
         .BLANK      (BLANK)
      ) u_path (
         .clk      (clk),
         .rst_n    (rst_n),
         .streams  (stream_clk),
         .ext_ref  (ext_v[p]),
         .wr_ratio (hit && (wr_addr[0] == FLD_RATIO)),
         .wr_source(hit && (wr_addr[0] == FLD_SOURCE)),
         .wr_data  (wr_data),
         .tick     (tick_v[p])
      );
   end

   assign pri_tick = tick_v[0];
   assign sec_tick = tick_v[1];
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk #(
   parameter int unsigned DIV_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [DIV_W-1:0] wr_data,
   input logic             pri_tick,
   input logic             sec_tick
);
   // ratio-is-zero shadow per path, tracked from the write port alone
   logic [1:0] zero_q;

   always_ff @(posedge clk) begin
      if (!rst_n) zero_q <= 2'b11;
      else if (wr_en && !wr_addr[0]) zero_q[wr_addr[1]] <= (wr_data == '0);
   end

   a_r4_pri_off: assert property (@(posedge clk) disable iff (!rst_n)
      zero_q[0] |-> !pri_tick);
   a_r4_sec_off: assert property (@(posedge clk) disable iff (!rst_n)
      zero_q[1] |-> !sec_tick);
   a_r5_pri_single: assert property (@(posedge clk) disable iff (!rst_n)
      pri_tick |=> !pri_tick);
   a_r5_sec_single: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick);
   a_r6_pri_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr[1]) |=> !pri_tick);
   a_r6_sec_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[1]) |=> !sec_tick);
endmodule

bind refdiv_pair refdiv_chk #(.DIV_W(DIV_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .pri_tick(pri_tick),
   .sec_tick(sec_tick)
);

// File: tb/sim_refdiv_pair.sv
`timescale 1ns/1ps
module sim_refdiv_pair;
   localparam int NS = 4;
   // periods in system clocks: streams 0..3, primary pin, secondary pin
   localparam int PER [6] = '{10, 12, 14, 18, 16, 20};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NS-1:0] stream_clk = '0;
   logic pri_ext_ref = 1'b0, sec_ext_ref = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [11:0] wr_data = '0;
   logic pri_tick, sec_tick;

   refdiv_pair u0 (.*);

   always #5 clk = ~clk;

   int tests = 0, fails = 0, cyc = 0;
   bit done = 1'b0;
   int edges [6] = '{default: 0};
   bit sv [6] = '{default: 1'b0};
   int tick_n [2] = '{default: 0};
   int last_t [2] = '{default: 0};
   int prev_t [2] = '{default: 0};
   int dbl [2] = '{default: 0};
   bit tprev [2] = '{default: 1'b0};

   always @(negedge clk) begin
      logic [1:0] tk;
      cyc++;
      for (int s = 0; s < 6; s++) begin
         bit v;
         v = (cyc % PER[s]) < (PER[s] / 2);
         if (v && !sv[s]) edges[s]++;
         sv[s] = v;
      end
      stream_clk  = {sv[3], sv[2], sv[1], sv[0]};
      pri_ext_ref = sv[4];
      sec_ext_ref = sv[5];
      tk = {sec_tick, pri_tick};
      for (int p = 0; p < 2; p++) begin
         if (tk[p]) begin
            if (tprev[p]) dbl[p]++;
            tick_n[p]++;
            prev_t[p] = last_t[p];
            last_t[p] = cyc;
         end
         tprev[p] = tk[p];
      end
   end

   task automatic chk(input string rq, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk); #1;
      wr_en = 1'b1; wr_addr = 2'(a); wr_data = 12'(d);
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic cfg(input int p, input int sel, input int n);
      wr(p * 2 + 1, sel);
      wr(p * 2, n);
   endtask

   task automatic measure(input int p, output int per);
      int base;
      base = tick_n[p];
      per = -1;
      for (int k = 0; k < 40000; k++) begin
         @(posedge clk);
         if (tick_n[p] >= base + 3) begin
            per = last_t[p] - prev_t[p];
            break;
         end
      end
   endtask

   task automatic wait_rise(input int s);
      int e;
      e = edges[s];
      while (edges[s] == e) @(posedge clk);
      repeat (4) @(posedge clk);
   endtask

   // write while the source is steady, then count source edges to the first strobe
   task automatic edge_test(input int p, input int s, input int selv, input int n,
                            input bit do_sel, input string rq);
      int e0, t0, got;
      wait_rise(s);
      e0 = edges[s];
      t0 = tick_n[p];
      if (do_sel) wr(p * 2 + 1, selv);
      else        wr(p * 2, n);
      got = -1;
      for (int k = 0; k < 5000; k++) begin
         @(posedge clk);
         if (tick_n[p] > t0) begin
            got = edges[s] - e0;
            break;
         end
      end
      chk(rq, got, n);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int per, base, other;
      int ns [4] = '{1, 2, 3, 5};
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (100) @(posedge clk);
      chk("R7 reset primary silent", tick_n[0], 0);
      chk("R7 reset secondary silent", tick_n[1], 0);

      // R1 R2 R3: every source on both paths, several ratios
      for (int p = 0; p < 2; p++) begin
         other = tick_n[1 - p];
         for (int si = 0; si < 5; si++) begin
            int s, selv;
            s    = (si < 4) ? si : 4 + p;
            selv = (si < 4) ? si : 4;
            for (int j = 0; j < 4; j++) begin
               cfg(p, selv, ns[j]);
               measure(p, per);
               chk($sformatf("R3 R2 path%0d src%0d N=%0d period", p, s, ns[j]),
                   per, ns[j] * PER[s]);
            end
         end
         wr(p * 2, 0);
         chk("R1 idle path unaffected", tick_n[1 - p], other);
      end

      // R4: zero ratio, from reset-like state and while running
      cfg(0, 2, 0);
      base = tick_n[0];
      repeat (300) @(posedge clk);
      chk("R4 primary zero ratio", tick_n[0] - base, 0);
      cfg(1, 0, 1);
      measure(1, per);
      chk("R3 secondary pass-through", per, PER[0]);
      wr(2, 0);
      repeat (2) @(posedge clk);
      base = tick_n[1];
      repeat (300) @(posedge clk);
      chk("R4 secondary zero after running", tick_n[1] - base, 0);

      // R2: top select code picks the pin
      cfg(0, 7, 2);
      measure(0, per);
      chk("R2 select 7 primary pin", per, 2 * PER[4]);
      cfg(1, 6, 2);
      measure(1, per);
      chk("R2 select 6 secondary pin", per, 2 * PER[5]);

      // R1: both paths at once with different settings
      cfg(0, 1, 3);
      cfg(1, 3, 2);
      measure(0, per);
      chk("R1 concurrent primary", per, 3 * PER[1]);
      measure(1, per);
      chk("R1 concurrent secondary", per, 2 * PER[3]);

      // R6: restart on ratio and select writes
      cfg(0, 2, 3);
      edge_test(0, 2, 0, 4, 1'b0, "R6 ratio rewrite primary");
      cfg(1, 0, 5);
      edge_test(1, 3, 3, 5, 1'b1, "R6 source switch secondary");
      edge_test(0, 4, 4, 4, 1'b1, "R6 source switch to primary pin");

      // R8: large ratio
      wr(2, 0);
      cfg(0, 4, 537);
      measure(0, per);
      chk("R8 ratio 537", per, 537 * PER[4]);

      chk("R5 primary one cycle wide", dbl[0], 0);
      chk("R5 secondary one cycle wide", dbl[1], 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule